// File: doc/BRIEF.md
# Multi-Channel Serial Management Slave

This block is the slave side of a two-wire serial management port in the clause-22 style. One slave serves four channels, and each channel exposes eleven 16-bit registers. The block samples MDIO on each rising edge of MDC. It waits for a preamble, then decodes the frame header: start, opcode, device address and register address. After the turnaround it either shifts data out to the master or shifts data in from it.

The 5-bit device address is split in two. Its three upper bits must equal a strap input. Its two lower bits pick the channel. The register contents sit outside this block and are reached through a parallel port that carries a channel, a register index, read and write strobes, and data.

When the burst-enable input is high and the register address is all ones, one frame moves all 44 registers. The data phase is then 704 bits long, ordered by channel and then by register. The read strobe fires once per word, just before that word's first bit leaves the slave. This lets latching status bits in the register file update at the moment they are read.

Top module: `mdio_mc_slave`

## Requirements
- R1: While rst_ni is low and right after reset, mdio_oe_o, rf_rd_o and rf_wr_o are all 0.
- R2: A frame is decoded only after at least 32 consecutive 1 bits in idle. A shorter run of ones leaves the frame ignored. Each new frame needs a fresh preamble.
- R3: The two start bits must be 0 then 1. Any other start pattern makes the slave ignore the frame: it does not drive MDIO and issues no strobe.
- R4: The device address is sent MSB first. Its upper three bits must equal strap_i, or the frame is ignored. Its lower two bits give the channel shown on rf_chan_o.
- R5: Opcode bits 1,0 (sent in that order) select a read, and 0,1 select a write. Opcodes 0,0 and 1,1 are ignored.
- R6: Valid register indices are 0–5 and 16–20. Index 31 is valid only when burst_en_i is 1. Any other index makes the frame ignored.
- R7: On a read, MDIO stays released (mdio_oe_o=0) during the first turnaround bit. During the second turnaround bit the slave drives 0.
- R8: Read data leaves MSB first, one bit per MDC period, changing after the rising edge. mdio_oe_o drops after the last data bit.
- R9: rf_rd_o pulses for one cycle in the bit period before each read word's first data bit. During the pulse rf_chan_o and rf_reg_o name that word, and the word is taken from rf_rdata_i in that cycle.
- R10: After the 16th data bit of a write word is sampled, rf_wr_o pulses for one cycle. During the pulse rf_wdata_o holds the word, and rf_chan_o and rf_reg_o name the register it goes to.
- R11: A burst frame (index 31 with burst enabled) carries 44 words. They run from channel 0 to channel 3, and within each channel through registers 0–5 and then 16–20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc_i | input | 1 | Management clock; every sample and update happens on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mdio_i | input | 1 | Serial data from the bus |
| mdio_o | output | 1 | Serial data driven by the slave |
| mdio_oe_o | output | 1 | Output enable for mdio_o |
| strap_i | input | 3 | Must equal the upper device-address bits |
| burst_en_i | input | 1 | Turns register index 31 into a burst of all registers |
| rf_chan_o | output | 2 | Channel of the register being accessed |
| rf_reg_o | output | 5 | Index of the register being accessed |
| rf_rd_o | output | 1 | One-cycle read strobe |
| rf_wr_o | output | 1 | One-cycle write strobe |
| rf_wdata_o | output | 16 | Write data |
| rf_rdata_i | input | 16 | Read data, valid in the strobe cycle |

## Verification
The assertions rely on a few conditions at the block's inputs. rf_rdata_i must answer within the same cycle as the read strobe. strap_i and burst_en_i must not change while a frame is in progress. The master must leave MDIO released, reading as 1, through the turnaround and data bits of a read. The bench meets these conditions as follows. Its register-file model computes rf_rdata_i combinationally from rf_chan_o and rf_reg_o. It changes burst_en_i only between frames. It drives 1 on mdio_i whenever the slave is expected to own the line. It also keeps the idle ones left over from the previous frame well short of a full preamble.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned REG_W         = 5;
  localparam int unsigned OP_W          = 2;
  localparam int unsigned REG_LO_LAST   = 5;
  localparam int unsigned REG_HI_FIRST  = 16;
  localparam int unsigned REG_HI_LAST   = 20;
  localparam int unsigned REGS_PER_CHAN = (REG_LO_LAST + 1) + (REG_HI_LAST - REG_HI_FIRST + 1);
  localparam logic [REG_W-1:0] BURST_REG = '1;
  localparam logic [OP_W-1:0]  OP_RD     = 2'b10;
  localparam logic [OP_W-1:0]  OP_WR     = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_TA1,
    ST_TA2,
    ST_DATA
  } mdio_state_e;

  function automatic logic reg_in_map(input logic [REG_W-1:0] r);
    return (r <= REG_W'(REG_LO_LAST)) ||
           ((r >= REG_W'(REG_HI_FIRST)) && (r <= REG_W'(REG_HI_LAST)));
  endfunction

  // register after r within one channel; caller handles the wrap
  function automatic logic [REG_W-1:0] reg_step(input logic [REG_W-1:0] r);
    return (r == REG_W'(REG_LO_LAST)) ? REG_W'(REG_HI_FIRST) : r + 1'b1;
  endfunction
endpackage

// File: rtl/mdio_preamble_det.sv
module mdio_preamble_det #(
  parameter int unsigned PRE_LEN = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic bit_i,
  output logic ok_o
);
  localparam int unsigned CW = $clog2(PRE_LEN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i || !bit_i)            cnt_q <= '0;
    else if (cnt_q != CW'(PRE_LEN))      cnt_q <= cnt_q + 1'b1;
  end

  assign ok_o = (cnt_q == CW'(PRE_LEN));
endmodule

// File: rtl/mdio_word_seq.sv
module mdio_word_seq
  import mdio_pkg::*;
#(
  parameter int unsigned CHAN_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              burst_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic              adv_i,
  output logic [CHAN_W-1:0] chan_o,
  output logic [REG_W-1:0]  reg_o
);
  logic [CHAN_W-1:0] chan_q;
  logic [REG_W-1:0]  reg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q <= '0;
      reg_q  <= '0;
    end else if (load_i) begin
      chan_q <= burst_i ? '0 : chan_i;
      reg_q  <= burst_i ? '0 : reg_i;
    end else if (adv_i) begin
      if (reg_q == REG_W'(REG_HI_LAST)) begin
        reg_q  <= '0;
        chan_q <= chan_q + 1'b1;
      end else begin
        reg_q  <= reg_step(reg_q);
      end
    end
  end

  assign chan_o = chan_q;
  assign reg_o  = reg_q;
endmodule

// File: rtl/mdio_shift_reg.sv
module mdio_shift_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= '0;
    else if (load_i)  q_q <= load_val_i;
    else if (shift_i) q_q <= {q_q[W-2:0], bit_i};
  end

  assign q_o = q_q;
endmodule

// File: rtl/mdio_mc_slave.sv
module mdio_mc_slave
  import mdio_pkg::*;
#(
  parameter int unsigned STRAP_W = 3,
  parameter int unsigned CHAN_W  = 2,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned PRE_LEN = 32
) (
  input  logic               mdc_i,
  input  logic               rst_ni,
  input  logic               mdio_i,
  output logic               mdio_o,
  output logic               mdio_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               burst_en_i,
  output logic [CHAN_W-1:0]  rf_chan_o,
  output logic [REG_W-1:0]   rf_reg_o,
  output logic               rf_rd_o,
  output logic               rf_wr_o,
  output logic [DATA_W-1:0]  rf_wdata_o,
  input  logic [DATA_W-1:0]  rf_rdata_i
);
  localparam int unsigned N_CHAN     = 1 << CHAN_W;
  localparam int unsigned PHY_W      = STRAP_W + CHAN_W;
  localparam int unsigned HDR_BITS   = 1 + OP_W + PHY_W + REG_W;  // second start bit onward
  localparam int unsigned HCW        = $clog2(HDR_BITS);
  localparam int unsigned WORDS      = N_CHAN * REGS_PER_CHAN;
  localparam int unsigned BURST_BITS = WORDS * DATA_W;
  localparam int unsigned DCW        = $clog2(BURST_BITS);
  localparam int unsigned WBW        = $clog2(DATA_W);

  mdio_state_e          state_q;
  logic [HCW-1:0]       hcnt_q;
  logic [HDR_BITS-2:0]  hdr_q;
  logic [DCW-1:0]       dcnt_q;
  logic                 is_rd_q;
  logic                 burst_q;
  logic                 wr_q;
  logic [DATA_W-1:0]    wdata_q;

  logic                 pre_ok;
  logic [HDR_BITS-1:0]  hdr_full;
  logic [REG_W-1:0]     f_reg;
  logic [CHAN_W-1:0]    f_chan;
  logic [STRAP_W-1:0]   f_strap;
  logic [OP_W-1:0]      f_op;
  logic                 f_start;
  logic                 f_burst;
  logic                 hdr_ok;
  logic                 hdr_done;
  logic                 seq_load;
  logic                 word_end;
  logic                 data_last;
  logic                 rd_load;
  logic                 wr_cap;
  logic [DATA_W-1:0]    sr_q;

  mdio_preamble_det #(.PRE_LEN(PRE_LEN)) u_pre (
    .clk_i  (mdc_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q != ST_IDLE),
    .bit_i  (mdio_i),
    .ok_o   (pre_ok)
  );

  // header fields, with the bit sampled this edge appended
  assign hdr_full = {hdr_q, mdio_i};
  assign f_reg    = hdr_full[REG_W-1:0];
  assign f_chan   = hdr_full[REG_W +: CHAN_W];
  assign f_strap  = hdr_full[REG_W+CHAN_W +: STRAP_W];
  assign f_op     = hdr_full[REG_W+PHY_W +: OP_W];
  assign f_start  = hdr_full[HDR_BITS-1];
  assign f_burst  = burst_en_i && (f_reg == BURST_REG);

  assign hdr_ok   = f_start && ((f_op == OP_RD) || (f_op == OP_WR)) &&
                    (f_strap == strap_i) && (reg_in_map(f_reg) || f_burst);
  assign hdr_done = (state_q == ST_HDR) && (hcnt_q == HCW'(HDR_BITS - 1));
  assign seq_load = hdr_done && hdr_ok;

  assign word_end  = (state_q == ST_DATA) && (dcnt_q[WBW-1:0] == WBW'(DATA_W - 1));
  assign data_last = (state_q == ST_DATA) &&
                     (dcnt_q == (burst_q ? DCW'(BURST_BITS - 1) : DCW'(DATA_W - 1)));
  // strobe in the bit period before a word's MSB; the word is loaded at its end
  assign rd_load   = is_rd_q && ((state_q == ST_TA2) || (word_end && !data_last));
  assign wr_cap    = word_end && !is_rd_q;

  mdio_word_seq #(.CHAN_W(CHAN_W)) u_seq (
    .clk_i   (mdc_i),
    .rst_ni  (rst_ni),
    .load_i  (seq_load),
    .burst_i (f_burst),
    .chan_i  (f_chan),
    .reg_i   (f_reg),
    .adv_i   (burst_q && (rd_load || wr_q)),
    .chan_o  (rf_chan_o),
    .reg_o   (rf_reg_o)
  );

  mdio_shift_reg #(.W(DATA_W)) u_sr (
    .clk_i      (mdc_i),
    .rst_ni     (rst_ni),
    .load_i     (rd_load),
    .load_val_i (rf_rdata_i),
    .shift_i    (state_q == ST_DATA),
    .bit_i      (mdio_i),
    .q_o        (sr_q)
  );

  always_ff @(posedge mdc_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hcnt_q  <= '0;
      hdr_q   <= '0;
      dcnt_q  <= '0;
      is_rd_q <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (pre_ok && !mdio_i) begin
            state_q <= ST_HDR;
            hcnt_q  <= '0;
          end
        end
        ST_HDR: begin
          hdr_q  <= hdr_full[HDR_BITS-2:0];
          hcnt_q <= hcnt_q + 1'b1;
          if (hdr_done) begin
            if (hdr_ok) begin
              state_q <= ST_TA1;
              is_rd_q <= (f_op == OP_RD);
              burst_q <= f_burst;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_TA1: state_q <= ST_TA2;
        ST_TA2: begin
          state_q <= ST_DATA;
          dcnt_q  <= '0;
        end
        ST_DATA: begin
          dcnt_q <= dcnt_q + 1'b1;
          if (data_last) begin
            state_q <= ST_IDLE;
            is_rd_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge mdc_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      wr_q <= wr_cap;
      if (wr_cap) wdata_q <= {sr_q[DATA_W-2:0], mdio_i};
    end
  end

  assign mdio_oe_o  = is_rd_q && ((state_q == ST_TA2) || (state_q == ST_DATA));
  assign mdio_o     = (state_q == ST_DATA) && sr_q[DATA_W-1];
  assign rf_rd_o    = rd_load;
  assign rf_wr_o    = wr_q;
  assign rf_wdata_o = wdata_q;
endmodule

// File: rtl/mdio_mc_slave_chk.sv
module mdio_mc_slave_chk (
  input logic       mdc_i,
  input logic       rst_ni,
  input logic       mdio_o,
  input logic       mdio_oe_o,
  input logic [4:0] rf_reg_o,
  input logic       rf_rd_o,
  input logic       rf_wr_o
);
  a_r9_rd_while_driving: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    rf_rd_o |-> mdio_oe_o);

  a_r9_rd_then_drive: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    rf_rd_o |=> mdio_oe_o);

  a_r9_rd_one_cycle: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    rf_rd_o |=> !rf_rd_o);

  a_r10_wr_one_cycle: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    rf_wr_o |=> !rf_wr_o);

  a_r10_wr_released: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    rf_wr_o |-> !mdio_oe_o);

  a_r7_ta2_drives_zero: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    $rose(mdio_oe_o) |-> !mdio_o);

  a_r6_reg_in_map: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    (rf_rd_o || rf_wr_o) |-> ((rf_reg_o <= 5'd5) || ((rf_reg_o >= 5'd16) && (rf_reg_o <= 5'd20))));
endmodule

bind mdio_mc_slave mdio_mc_slave_chk u_chk (
  .mdc_i     (mdc_i),
  .rst_ni    (rst_ni),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o),
  .rf_reg_o  (rf_reg_o),
  .rf_rd_o   (rf_rd_o),
  .rf_wr_o   (rf_wr_o)
);

// File: tb/mdio_mc_slave_tb_top.sv
module mdio_mc_slave_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdio_i = 1'b1;
  logic        mdio_o;
  logic        mdio_oe;
  logic [2:0]  strap = 3'b101;
  logic        burst_en = 1'b0;
  logic [1:0]  rf_chan;
  logic [4:0]  rf_reg;
  logic        rf_rd;
  logic        rf_wr;
  logic [15:0] rf_wdata;
  logic [15:0] rf_rdata;

  int tests = 0;
  int fails = 0;
  int ev_cnt = 0;

  typedef struct {
    bit        wr;
    bit [1:0]  ch;
    bit [4:0]  rg;
    bit [15:0] d;
    string     tag;
  } item_t;
  item_t exp_q[$];

  always #4 clk = ~clk;  // 125 MHz

  function automatic bit [15:0] mdl(input bit [1:0] c, input bit [4:0] r);
    return {4'hA, c, 2'b01, r[0], ~r[0], r, 1'b1};
  endfunction

  function automatic bit [1:0] b_chan(input int w);
    return 2'(w / 11);
  endfunction

  function automatic bit [4:0] b_reg(input int w);
    int r;
    r = w % 11;
    return (r < 6) ? 5'(r) : 5'(r + 10);
  endfunction

  function automatic bit [15:0] wd(input int w, input bit [15:0] seed);
    return seed ^ 16'(w * 291);
  endfunction

  assign rf_rdata = mdl(rf_chan, rf_reg);

  mdio_mc_slave dut_i (
    .mdc_i      (clk),
    .rst_ni     (rst_n),
    .mdio_i     (mdio_i),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe),
    .strap_i    (strap),
    .burst_en_i (burst_en),
    .rf_chan_o  (rf_chan),
    .rf_reg_o   (rf_reg),
    .rf_rd_o    (rf_rd),
    .rf_wr_o    (rf_wr),
    .rf_wdata_o (rf_wdata),
    .rf_rdata_i (rf_rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each strobe
  always @(negedge clk) begin
    if (rst_n && (rf_rd || rf_wr)) begin
      ev_cnt++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R9/R10 unexpected strobe", {rf_wr, rf_rd, rf_chan, rf_reg}, 0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check(rf_wr == it.wr && rf_rd == !it.wr, {it.tag, " strobe kind"}, {rf_wr, rf_rd}, {it.wr, !it.wr});
        check(rf_chan == it.ch && rf_reg == it.rg, {it.tag, " address"}, {rf_chan, rf_reg}, {it.ch, it.rg});
        if (it.wr) check(rf_wdata == it.d, {it.tag, " write data"}, rf_wdata, it.d);
      end
    end
  end

  task automatic drive(input bit b);
    @(negedge clk);
    mdio_i = b;
  endtask

  task automatic send_hdr(input int pre, input bit [1:0] st, input bit [1:0] op,
                          input bit [2:0] ph, input bit [1:0] ch, input bit [4:0] rg);
    drive(1'b0);
    repeat (pre) drive(1'b1);
    drive(st[1]); drive(st[0]);
    drive(op[1]); drive(op[0]);
    for (int i = 2; i >= 0; i--) drive(ph[i]);
    for (int i = 1; i >= 0; i--) drive(ch[i]);
    for (int i = 4; i >= 0; i--) drive(rg[i]);
  endtask

  task automatic read_frame(input int pre, input bit [1:0] st, input bit [1:0] op,
                            input bit [2:0] ph, input bit [1:0] ch, input bit [4:0] rg,
                            input bit ok, input int n, input string tag);
    int ev0;
    ev0 = ev_cnt;
    if (ok) begin
      for (int w = 0; w < n; w++) begin
        item_t it;
        it.wr = 1'b0;
        it.ch = (n > 1) ? b_chan(w) : ch;
        it.rg = (n > 1) ? b_reg(w) : rg;
        it.d  = '0;
        it.tag = tag;
        exp_q.push_back(it);
      end
    end
    send_hdr(pre, st, op, ph, ch, rg);
    @(negedge clk); mdio_i = 1'b1;
    check(mdio_oe == 1'b0, "R7 first turnaround released", mdio_oe, 0);
    @(negedge clk);
    check(mdio_oe == ok && (!ok || mdio_o == 1'b0), "R7 second turnaround", {mdio_oe, mdio_o}, {ok, 1'b0});
    for (int w = 0; w < n; w++) begin
      bit [15:0] d;
      d = (n > 1) ? mdl(b_chan(w), b_reg(w)) : mdl(ch, rg);
      for (int b = 15; b >= 0; b--) begin
        @(negedge clk);
        if (ok) check(mdio_oe && mdio_o == d[b], {tag, " R8 data bit"}, {mdio_oe, mdio_o}, {1'b1, d[b]});
        else    check(!mdio_oe, {tag, " ignored read stays released"}, mdio_oe, 0);
      end
    end
    @(negedge clk);
    check(!mdio_oe, "R8 released after data", mdio_oe, 0);
    check(ev_cnt == ev0 + (ok ? n : 0), {tag, " read strobe count"}, ev_cnt - ev0, ok ? n : 0);
  endtask

  task automatic write_frame(input int pre, input bit [1:0] st, input bit [1:0] op,
                             input bit [2:0] ph, input bit [1:0] ch, input bit [4:0] rg,
                             input bit ok, input int n, input bit [15:0] seed, input string tag);
    int ev0;
    ev0 = ev_cnt;
    if (ok) begin
      for (int w = 0; w < n; w++) begin
        item_t it;
        it.wr = 1'b1;
        it.ch = (n > 1) ? b_chan(w) : ch;
        it.rg = (n > 1) ? b_reg(w) : rg;
        it.d  = wd(w, seed);
        it.tag = tag;
        exp_q.push_back(it);
      end
    end
    send_hdr(pre, st, op, ph, ch, rg);
    drive(1'b1); drive(1'b0);
    for (int w = 0; w < n; w++) begin
      bit [15:0] d;
      d = wd(w, seed);
      for (int b = 15; b >= 0; b--) drive(d[b]);
    end
    drive(1'b1); drive(1'b1);
    check(ev_cnt == ev0 + (ok ? n : 0), {tag, " write strobe count"}, ev_cnt - ev0, ok ? n : 0);
    check(!mdio_oe, {tag, " no drive on write"}, mdio_oe, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!mdio_oe, "R1 oe in reset", mdio_oe, 0);
    check(!rf_rd, "R1 rd in reset", rf_rd, 0);
    check(!rf_wr, "R1 wr in reset", rf_wr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mdio_oe && !rf_rd && !rf_wr, "R1 idle after reset", {mdio_oe, rf_rd, rf_wr}, 0);

    write_frame(32, 2'b01, 2'b01, 3'b101, 2'd1, 5'd3, 1'b1, 1, 16'hC3A5, "R10 R5 write ch1 r3");
    read_frame (32, 2'b01, 2'b10, 3'b101, 2'd2, 5'd17, 1'b1, 1, "R9 R4 read ch2 r17");
    read_frame (40, 2'b01, 2'b10, 3'b101, 2'd3, 5'd20, 1'b1, 1, "R6 read ch3 r20");
    read_frame (32, 2'b01, 2'b10, 3'b101, 2'd0, 5'd0, 1'b1, 1, "R6 read ch0 r0");
    write_frame(32, 2'b01, 2'b01, 3'b101, 2'd3, 5'd16, 1'b1, 1, 16'h0F0F, "R10 write ch3 r16");

    read_frame (31, 2'b01, 2'b10, 3'b101, 2'd1, 5'd1, 1'b0, 1, "R2 short preamble");
    write_frame(31, 2'b01, 2'b01, 3'b101, 2'd1, 5'd1, 1'b0, 1, 16'h1234, "R2 short preamble write");
    read_frame (32, 2'b00, 2'b10, 3'b101, 2'd1, 5'd1, 1'b0, 1, "R3 bad start");
    read_frame (32, 2'b01, 2'b10, 3'b100, 2'd1, 5'd1, 1'b0, 1, "R4 strap mismatch");
    write_frame(32, 2'b01, 2'b01, 3'b001, 2'd2, 5'd2, 1'b0, 1, 16'h5555, "R4 strap mismatch write");
    read_frame (32, 2'b01, 2'b11, 3'b101, 2'd1, 5'd1, 1'b0, 1, "R5 opcode 11");
    write_frame(32, 2'b01, 2'b00, 3'b101, 2'd1, 5'd1, 1'b0, 1, 16'h6666, "R5 opcode 00");
    read_frame (32, 2'b01, 2'b10, 3'b101, 2'd0, 5'd6, 1'b0, 1, "R6 index 6");
    read_frame (32, 2'b01, 2'b10, 3'b101, 2'd0, 5'd15, 1'b0, 1, "R6 index 15");
    write_frame(32, 2'b01, 2'b01, 3'b101, 2'd0, 5'd21, 1'b0, 1, 16'h7777, "R6 index 21");
    read_frame (32, 2'b01, 2'b10, 3'b101, 2'd0, 5'd31, 1'b0, 1, "R6 index 31 no burst");

    @(negedge clk); burst_en = 1'b1;
    read_frame (32, 2'b01, 2'b10, 3'b101, 2'd2, 5'd31, 1'b1, 44, "R11 burst read");
    write_frame(32, 2'b01, 2'b01, 3'b101, 2'd1, 5'd31, 1'b1, 44, 16'h9E37, "R11 burst write");
    read_frame (32, 2'b01, 2'b10, 3'b101, 2'd1, 5'd4, 1'b1, 1, "R11 single read with burst enabled");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R9 R10 scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog (R1-all): actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule